// File: doc/BRIEF.md
# Nibble-Packed Allocation Tag Store

This block holds 4-bit memory allocation tags, one tag for each 16-byte granule of data memory. Two tags share one byte of a local synchronous tag RAM, so the RAM holds half as many bytes as it covers granules. One request port carries three operations: read the tag of a granule, write the tag of a granule, and write one tag to two neighbouring granules. A read returns a 64-bit register value with the loaded tag placed in its tag field. A write takes its tag from the same field of the data word.

Every request carries a flag saying whether its page has tag storage. When the flag is low, reads return tag zero and writes leave the RAM alone. Writes still get their alignment check, and a misaligned write raises a fault.

Writes that change only one nibble read the RAM byte, merge the new nibble into it and write the byte back. A paired write on a 32-byte boundary writes one whole byte. A paired write that starts on an odd granule changes two bytes, one after the other. While an operation is in flight, `busy` is high and new requests are ignored. `done` pulses once when the operation ends.

Top module: `tagnib_store`

## Requirements
- R1: The operation code `req_op` is 0 for a tag load, 1 for a single tag store and 2 for a paired tag store; any other code is treated as a load. The tag RAM byte index is `req_addr >> 5`, and address bit 4 selects the nibble: 0 selects bits [3:0] and 1 selects bits [7:4]. Address bits [3:0] are ignored by a load. A load returns `req_data` with bits [59:56] replaced by the selected tag.
- R2: A load whose `req_tagok` is low returns `req_data` with bits [59:56] set to 0.
- R3: A single store with bits [3:0] of the address equal to zero writes `req_data[59:56]` into the selected nibble and leaves the other nibble of that byte unchanged.
- R4: A single or paired store whose address bits [3:0] are not all zero asserts `fault` together with `done` and changes no tag.
- R5: A paired store whose address bits [4:0] are zero writes the tag into both nibbles of its byte.
- R6: A paired store at an aligned address with bit 4 set writes bits [7:4] of byte k and bits [3:0] of byte k+1, taken modulo the RAM depth. All other nibbles stay unchanged.
- R7: A store whose `req_tagok` is low changes no tag and raises no fault when aligned. The alignment fault of R4 still applies.
- R8: A request is accepted on a clock edge where `req_valid` is high and `busy` is low. `busy` is then high until the operation completes, and any request presented while `busy` is high is ignored.
- R9: `done` is high for exactly one cycle per accepted operation. It rises on the first edge after the accepting edge, except for a paired store at an odd granule with tag storage, where it rises on the second edge.
- R10: After reset, `busy`, `done`, `fault` and `rsp_data` are zero. With the default clear option, every tag reads as 0.
- R11: `rsp_data` changes only on completion of a load and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 0 load, 1 single store, 2 paired store |
| req_addr | input | ADDR_W | Byte address of the granule |
| req_data | input | DATA_W | Register value; tag field at bits [59:56] |
| req_tagok | input | 1 | Page has tag storage |
| busy | output | 1 | Operation in flight; requests ignored |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Alignment fault, valid with done |
| rsp_data | output | DATA_W | Load result, held until the next load |

## Verification
The bench builds the block with ADDR_W = 10, which gives a tag RAM of only 32 bytes. With so few bytes, random addresses keep hitting bytes that are already partly written, so the nibble merges of R3 and R6 meet live neighbouring tags. The small depth also puts the wrap-around of an odd paired store from the last byte to byte 0 within a single directed case. The clear-on-reset option is left on, so the bench model can start from all-zero tags.

// File: rtl/tagnib_pkg.sv
package tagnib_pkg;
   typedef enum logic [1:0] {
      OP_LOAD  = 2'd0,
      OP_STORE = 2'd1,
      OP_PAIR  = 2'd2,
      OP_RSVD  = 2'd3
   } tn_op_e;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_FIRST  = 2'd1,
      ST_SECOND = 2'd2
   } tn_state_e;

   localparam int TN_TAG_W = 4;
endpackage

// File: rtl/tagnib_ram.sv
module tagnib_ram #(
   parameter int IDX_W = 7,
   parameter bit CLEAR = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [7:0]       rd_byte,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [7:0]       wr_byte
);
   localparam int DEPTH = 1 << IDX_W;

   logic [7:0] mem [DEPTH];

   generate
      if (CLEAR) begin : g_clear
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
            end else if (wr_en) begin
               mem[wr_idx] <= wr_byte;
            end
         end
      end else begin : g_noclear
         always_ff @(posedge clk) begin
            if (wr_en) mem[wr_idx] <= wr_byte;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_byte <= 8'h00;
      else        rd_byte <= mem[rd_idx];
   end
endmodule

// File: rtl/tagnib_lane_merge.sv
module tagnib_lane_merge #(
   parameter int TAG_W = 4
) (
   input  logic [2*TAG_W-1:0] old_byte,
   input  logic [TAG_W-1:0]   tag,
   input  logic [1:0]         lanes,
   output logic [2*TAG_W-1:0] new_byte
);
   generate
      for (genvar l = 0; l < 2; l++) begin : g_lane
         assign new_byte[l*TAG_W +: TAG_W] = lanes[l] ? tag : old_byte[l*TAG_W +: TAG_W];
      end
   endgenerate
endmodule

// File: rtl/tagnib_ctrl.sv
module tagnib_ctrl
   import tagnib_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int GRAN_LOG2 = 4,
   parameter int DATA_W    = 64,
   parameter int TAG_LSB   = 56,
   parameter int IDX_W     = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_data,
   input  logic              req_tagok,
   output logic              busy,
   output logic              done,
   output logic              fault,
   output logic [DATA_W-1:0] rsp_data,
   output logic [IDX_W-1:0]  rd_idx,
   input  logic [7:0]        rd_byte,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [1:0]        wr_lanes,
   output logic [TN_TAG_W-1:0] wr_tag
);
   localparam int HALF_BIT = GRAN_LOG2;
   localparam int IDX_LSB  = GRAN_LOG2 + 1;
   localparam logic [DATA_W-1:0] TAG_MASK = DATA_W'({TN_TAG_W{1'b1}}) << TAG_LSB;

   tn_state_e          state, nxt_state;
   tn_op_e             op_q;
   logic [IDX_W-1:0]   idx_q, idx_nx;
   logic               half_q, mis_q, tagok_q;
   logic [DATA_W-1:0]  data_q;
   logic               fin, flt, upd_rsp, is_store_q;
   logic [TN_TAG_W-1:0] picked, ins_tag;
   logic [IDX_W-1:0]   req_idx;

   assign req_idx    = req_addr[IDX_LSB +: IDX_W];
   assign idx_nx     = IDX_W'(idx_q + 1'b1);
   assign is_store_q = (op_q == OP_STORE) || (op_q == OP_PAIR);
   assign picked     = half_q ? rd_byte[7:4] : rd_byte[3:0];
   assign ins_tag    = tagok_q ? picked : '0;
   assign wr_tag     = data_q[TAG_LSB +: TN_TAG_W];
   assign busy       = (state != ST_IDLE);
   assign rd_idx     = (state == ST_FIRST) ? idx_nx : req_idx;
   assign wr_idx     = (state == ST_SECOND) ? idx_nx : idx_q;

   always_comb begin
      nxt_state = state;
      fin       = 1'b0;
      flt       = 1'b0;
      upd_rsp   = 1'b0;
      wr_en     = 1'b0;
      wr_lanes  = 2'b00;
      unique case (state)
         ST_IDLE: begin
            if (req_valid) nxt_state = ST_FIRST;
         end
         ST_FIRST: begin
            if (!is_store_q) begin
               upd_rsp = 1'b1;
               fin     = 1'b1;
            end else if (mis_q) begin
               flt = 1'b1;
               fin = 1'b1;
            end else if (!tagok_q) begin
               fin = 1'b1;
            end else if (op_q == OP_STORE) begin
               wr_en    = 1'b1;
               wr_lanes = half_q ? 2'b10 : 2'b01;
               fin      = 1'b1;
            end else if (!half_q) begin
               wr_en    = 1'b1;
               wr_lanes = 2'b11;
               fin      = 1'b1;
            end else begin
               wr_en     = 1'b1;
               wr_lanes  = 2'b10;
               nxt_state = ST_SECOND;
            end
            if (fin) nxt_state = ST_IDLE;
         end
         ST_SECOND: begin
            wr_en     = 1'b1;
            wr_lanes  = 2'b01;
            fin       = 1'b1;
            nxt_state = ST_IDLE;
         end
         default: nxt_state = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         op_q     <= OP_LOAD;
         idx_q    <= '0;
         half_q   <= 1'b0;
         mis_q    <= 1'b0;
         tagok_q  <= 1'b0;
         data_q   <= '0;
         done     <= 1'b0;
         fault    <= 1'b0;
         rsp_data <= '0;
      end else begin
         state <= nxt_state;
         done  <= fin;
         fault <= flt;
         if (state == ST_IDLE && req_valid) begin
            op_q    <= tn_op_e'(req_op);
            idx_q   <= req_idx;
            half_q  <= req_addr[HALF_BIT];
            mis_q   <= (req_addr[GRAN_LOG2-1:0] != '0);
            tagok_q <= req_tagok;
            data_q  <= req_data;
         end
         if (upd_rsp) rsp_data <= (data_q & ~TAG_MASK) | (DATA_W'(ins_tag) << TAG_LSB);
      end
   end
endmodule

// File: rtl/tagnib_store.sv
module tagnib_store
   import tagnib_pkg::*;
#(
   parameter int ADDR_W         = 12,
   parameter int GRAN_LOG2      = 4,
   parameter int DATA_W         = 64,
   parameter int TAG_LSB        = 56,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_data,
   input  logic              req_tagok,
   output logic              busy,
   output logic              done,
   output logic              fault,
   output logic [DATA_W-1:0] rsp_data
);
   localparam int IDX_W = ADDR_W - GRAN_LOG2 - 1;

   generate
      if (GRAN_LOG2 < 1) begin : g_bad_gran
         $error("tagnib_store: GRAN_LOG2 must be at least 1");
      end
      if (IDX_W < 1) begin : g_bad_addr
         $error("tagnib_store: ADDR_W too small for one tag byte");
      end
      if (TAG_LSB + TN_TAG_W > DATA_W) begin : g_bad_field
         $error("tagnib_store: tag field does not fit in DATA_W");
      end
   endgenerate

   logic [IDX_W-1:0]    rd_idx, wr_idx;
   logic [7:0]          rd_byte, wr_byte;
   logic                wr_en;
   logic [1:0]          wr_lanes;
   logic [TN_TAG_W-1:0] wr_tag;

   tagnib_ctrl #(
      .ADDR_W(ADDR_W), .GRAN_LOG2(GRAN_LOG2), .DATA_W(DATA_W),
      .TAG_LSB(TAG_LSB), .IDX_W(IDX_W)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_data(req_data), .req_tagok(req_tagok),
      .busy(busy), .done(done), .fault(fault), .rsp_data(rsp_data),
      .rd_idx(rd_idx), .rd_byte(rd_byte), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_lanes(wr_lanes), .wr_tag(wr_tag)
   );

   tagnib_lane_merge #(.TAG_W(TN_TAG_W)) u_merge (
      .old_byte(rd_byte), .tag(wr_tag), .lanes(wr_lanes), .new_byte(wr_byte)
   );

   tagnib_ram #(.IDX_W(IDX_W), .CLEAR(CLEAR_ON_RESET)) u_ram (
      .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_byte(rd_byte),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_byte(wr_byte)
   );
endmodule

// File: rtl/tagnib_store_chk.sv
module tagnib_store_chk #(
   parameter int DATA_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              busy,
   input logic              done,
   input logic              fault,
   input logic [DATA_W-1:0] rsp_data
);
   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_fault_with_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> done);

   p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy) |=> busy);

   p_done_frees_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(rsp_data));
endmodule

bind tagnib_store tagnib_store_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy),
   .done(done), .fault(fault), .rsp_data(rsp_data)
);

// File: tb/tagnib_store_tb.sv
`timescale 1ns/1ps
module tagnib_store_tb;
   localparam int ADDR_W = 10;
   localparam int NB     = 32;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic [1:0]        req_op = 2'd0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [63:0]       req_data = '0;
   logic              req_tagok = 1'b0;
   logic              busy, done, fault;
   logic [63:0]       rsp_data;

   int checks = 0;
   int errors = 0;
   logic [7:0]  m [NB];
   logic [63:0] exp_rsp = '0;

   always #2.5 clk = ~clk;

   tagnib_store #(.ADDR_W(ADDR_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_data(req_data), .req_tagok(req_tagok),
      .busy(busy), .done(done), .fault(fault), .rsp_data(rsp_data)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [3:0] mtag(input logic [ADDR_W-1:0] a);
      logic [7:0] b;
      b = m[a[9:5]];
      return a[4] ? b[7:4] : b[3:0];
   endfunction

   task automatic run_op(input logic [1:0] op, input logic [ADDR_W-1:0] a,
                         input logic [63:0] d, input logic ok, input bit inject);
      logic       st, mis;
      int         n, exp_n;
      logic [3:0] t;
      logic [4:0] i;
      string      rq;
      st    = (op == 2'd1) || (op == 2'd2);
      mis   = (a[3:0] != 4'h0);
      t     = d[59:56];
      i     = a[9:5];
      exp_n = (op == 2'd2 && !mis && ok && a[4]) ? 3 : 2;
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_addr = a; req_data = d; req_tagok = ok;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R8 busy after accept", {63'd0, busy}, 64'd1);
      if (inject) begin
         req_valid = 1'b1; req_op = 2'd1; req_addr = {a[9:4], 4'h0};
         req_data = 64'h0F00_0000_0000_0000; req_tagok = 1'b1;
      end
      n = 1;
      while (!done && n < 8) begin
         @(negedge clk);
         req_valid = 1'b0;
         n++;
      end
      chk("R9 done latency", 64'(n), 64'(exp_n));
      chk("R8 idle at done", {63'd0, busy}, 64'd0);
      rq = !st ? (ok ? "R1 load" : "R2 load no tags") : (mis ? "R4 misaligned" : (ok ? "R3/R5/R6 store" : "R7 store no tags"));
      chk({rq, " fault"}, {63'd0, fault}, {63'd0, st && mis});
      if (!st) exp_rsp = {d[63:60], (ok ? mtag(a) : 4'h0), d[55:0]};
      else if (!mis && ok) begin
         if (op == 2'd1) begin
            if (a[4]) m[i][7:4] = t; else m[i][3:0] = t;
         end else if (!a[4]) m[i] = {t, t};
         else begin
            m[i][7:4] = t;
            m[5'(i + 1)][3:0] = t;
         end
      end
      chk(st ? "R11 rsp hold" : {rq, " data"}, rsp_data, exp_rsp);
      @(negedge clk);
      chk("R9 single pulse", {63'd0, done}, 64'd0);
   endtask

   task automatic ld(input logic [ADDR_W-1:0] a);
      run_op(2'd0, a, {$urandom, $urandom}, 1'b1, 1'b0);
   endtask

   function automatic logic [63:0] tg(input logic [3:0] t);
      return {4'h3, t, 56'h00A5_5A00_1234_56};
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      for (int k = 0; k < NB; k++) m[k] = 8'h00;
      repeat (3) @(negedge clk);
      chk("R10 busy reset", {63'd0, busy}, 64'd0);
      chk("R10 done reset", {63'd0, done}, 64'd0);
      chk("R10 fault reset", {63'd0, fault}, 64'd0);
      chk("R10 rsp reset", rsp_data, 64'd0);
      rst_n = 1'b1;
      // R10: cleared RAM reads as zero
      ld(10'h000);
      ld(10'h3F0);
      // R3 lower and upper nibbles, R1 low bits ignored
      run_op(2'd1, 10'h000, tg(4'h5), 1'b1, 1'b0);
      run_op(2'd1, 10'h010, tg(4'hA), 1'b1, 1'b0);
      ld(10'h000); ld(10'h01F); ld(10'h007);
      // R4 misaligned single and paired stores
      run_op(2'd1, 10'h024, tg(4'h7), 1'b1, 1'b0);
      run_op(2'd2, 10'h032, tg(4'h7), 1'b1, 1'b0);
      ld(10'h020); ld(10'h030);
      // R5 aligned pair
      run_op(2'd2, 10'h040, tg(4'hC), 1'b1, 1'b0);
      ld(10'h040); ld(10'h050);
      // R6 odd-granule pair and wrap
      run_op(2'd2, 10'h070, tg(4'h9), 1'b1, 1'b0);
      ld(10'h060); ld(10'h070); ld(10'h080); ld(10'h090);
      run_op(2'd2, 10'h3F0, tg(4'h6), 1'b1, 1'b0);
      ld(10'h3E0); ld(10'h3F0); ld(10'h000); ld(10'h010);
      // R7 no tag storage: aligned skipped, misaligned faults
      run_op(2'd1, 10'h0A0, tg(4'h3), 1'b0, 1'b0);
      run_op(2'd2, 10'h0B0, tg(4'h3), 1'b0, 1'b0);
      run_op(2'd1, 10'h0A8, tg(4'h3), 1'b0, 1'b0);
      ld(10'h0A0); ld(10'h0B0); ld(10'h0C0);
      // R2 load with no tag storage
      run_op(2'd0, 10'h010, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0);
      // R8 request while busy is ignored
      run_op(2'd0, 10'h100, tg(4'h1), 1'b1, 1'b1);
      run_op(2'd2, 10'h130, tg(4'h2), 1'b1, 1'b1);
      ld(10'h100); ld(10'h130); ld(10'h140);
      // random mix
      for (int k = 0; k < 500; k++) begin
         logic [ADDR_W-1:0] a;
         logic [1:0] op;
         a  = ADDR_W'($urandom);
         if ($urandom % 5 != 0) a[3:0] = 4'h0;
         op = 2'($urandom % 3);
         run_op(op, a, {$urandom, $urandom}, ($urandom % 7) != 0, ($urandom % 9) == 0);
      end
      for (int k = 0; k < 2 * NB; k++) ld(ADDR_W'(k * 16));
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule